// File: doc/BRIEF.md
# Channel Interleave Address Translator

This block turns a physical address that has already been matched to a target-address rule into two results: the channel the address belongs to, and the address as seen inside that channel. It first picks the channel. It drops the cache-line bits, then removes the socket interleave from the address. If the rule asks for it, it folds an XOR hash of paired upper address bits into the low bits of the result. It then reduces the result modulo the channel ways and uses that value to index the rule's target list.

It then de-interleaves the address in two steps, each at its own granularity. The first step subtracts the per-channel offset and strips the socket interleave. The second step strips the channel interleave. Each step keeps the low address bits below its granularity untouched.

Interleave ways are restricted to powers of two, so every division is a shift. A three-way channel interleave gets its own failure code. The datapath is 46 bits wide and pipelined over three stages. Each accepted request gives exactly one result, three clock cycles later and in order.

Top module: `chan_ilv_xlat`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is low.
- R2: Each request taken with in_valid high gives exactly one result with out_valid high, exactly three clock edges later, in request order.
- R3: The index is computed as follows. Take addr >> 6. Shift it right one more bit when in_chan_shift is 1. Divide by in_sock_ways. Reduce modulo in_chan_ways. out_chan_id is the 3-bit entry in_tgt_list[3*index +: 3].
- R4: When in_chan_hash is 1, each 2-bit field addr[i+1:i] for i = 12, 14, ..., 26 is XORed into the index after the socket division and before the modulo.
- R5: Granularity code 0 (64 B) gives shift 6, or 7 when in_chan_shift is 1. Code 1 (256 B) gives 8, code 2 (4 KB) gives 12 and code 3 (1 GB) gives 30.
- R6: The channel address is built in two steps, with sshift and cshift taken from the socket and channel granularity codes. First, t = (((addr - offset) >> sshift) / sock_ways) << sshift, OR addr[sshift-1:0]. Then, out_chan_addr = ((t >> cshift) / chan_ways) << cshift, OR addr[cshift-1:0].
- R7: in_chan_ways equal to 3 fails with code 2, ahead of every other failure.
- R8: A socket or channel ways value other than 1, 2, 4 or 8 (and not the 3-way case) fails with code 1.
- R9: An index at or above in_tgt_count fails with code 3. This check ranks below codes 2 and 1.
- R10: An offset greater than the address fails with code 4. This is the lowest-priority failure. An offset equal to the address is legal.
- R11: A successful result has out_fail 0. On any failure, out_chan_id and out_chan_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_addr | input | 46 | Physical address |
| in_offset | input | 46 | Per-channel offset for the matched rule |
| in_sock_ways | input | 4 | Socket interleave ways |
| in_chan_ways | input | 4 | Channel interleave ways |
| in_sock_gran | input | 2 | Socket granularity code |
| in_chan_gran | input | 2 | Channel granularity code |
| in_chan_shift | input | 1 | Use one extra line bit in the index and the 64 B granularity |
| in_chan_hash | input | 1 | Fold the paired-bit XOR hash into the index |
| in_tgt_count | input | 4 | Number of valid target-list entries |
| in_tgt_list | input | 24 | Eight 3-bit channel ids, entry k at bits 3k+2..3k |
| out_valid | output | 1 | Result present |
| out_fail | output | 3 | 0 ok, 1 bad ways, 2 three-way, 3 index beyond list, 4 offset underflow |
| out_chan_id | output | 3 | Selected channel id |
| out_chan_addr | output | 46 | Channel-local address |

## Verification
The hardest outcome to reach is the offset underflow. It shows only after the ways checks and the target-count check have all passed. So the stimulus must pick legal ways, pick a list count above the computed index, and still set an offset just one above the address. Directed requests build exactly that case, next to an offset equal to the address. The hash path is reached by setting a single bit in the 12..27 range so that the folded value moves the index by a known amount. A reference model, written with true division and modulo rather than shifts, scores long runs of random back-to-back requests.

// File: rtl/chan_ilv_pkg.sv
package chan_ilv_pkg;

    localparam int LINE_SHIFT = 6;
    localparam int HASH_LO    = 12;
    localparam int HASH_HI    = 26;

    typedef enum logic [2:0] {
        FAIL_NONE  = 3'd0,
        FAIL_WAYS  = 3'd1,
        FAIL_THREE = 3'd2,
        FAIL_TGT   = 3'd3,
        FAIL_UNDER = 3'd4
    } fail_e;

    typedef enum logic [1:0] {
        GRAN_64B  = 2'd0,
        GRAN_256B = 2'd1,
        GRAN_4KB  = 2'd2,
        GRAN_1GB  = 2'd3
    } gran_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] lg;
    } ways_t;

    typedef struct packed {
        logic       three;
        logic       ways_ok;
        logic [1:0] lg_s;
        logic [1:0] lg_c;
        logic [4:0] sshift;
        logic [4:0] cshift;
        logic [3:0] ishift;
    } cfg_t;

    function automatic ways_t ways_decode(input logic [31:0] w);
        ways_t r;
        r.ok = 1'b1;
        case (w)
            32'd1:   r.lg = 2'd0;
            32'd2:   r.lg = 2'd1;
            32'd4:   r.lg = 2'd2;
            32'd8:   r.lg = 2'd3;
            default: begin
                r.ok = 1'b0;
                r.lg = 2'd0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [4:0] gran_shift(input gran_e g, input logic cs);
        logic [4:0] s;
        case (g)
            GRAN_64B:  s = cs ? 5'd7 : 5'd6;
            GRAN_256B: s = 5'd8;
            GRAN_4KB:  s = 5'd12;
            default:   s = 5'd30;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/chan_ilv_cfg.sv
module chan_ilv_cfg
    import chan_ilv_pkg::*;
#(
    parameter int WAYS_W = 4
) (
    input  logic [WAYS_W-1:0] sock_ways_i,
    input  logic [WAYS_W-1:0] chan_ways_i,
    input  logic [1:0]        sock_gran_i,
    input  logic [1:0]        chan_gran_i,
    input  logic              chan_shift_i,
    output cfg_t              cfg_o
);
    localparam int PAD_W = 32 - WAYS_W;

    ways_t sw;
    ways_t cw;

    always_comb begin
        sw = ways_decode({{PAD_W{1'b0}}, sock_ways_i});
        cw = ways_decode({{PAD_W{1'b0}}, chan_ways_i});
        cfg_o.three   = (chan_ways_i == WAYS_W'(3));
        cfg_o.ways_ok = sw.ok && cw.ok;
        cfg_o.lg_s    = sw.lg;
        cfg_o.lg_c    = cw.lg;
        cfg_o.sshift  = gran_shift(gran_e'(sock_gran_i), chan_shift_i);
        cfg_o.cshift  = gran_shift(gran_e'(chan_gran_i), chan_shift_i);
        cfg_o.ishift  = 4'(LINE_SHIFT) + {3'd0, chan_shift_i} + {2'd0, sw.lg};
    end
endmodule

// File: rtl/chan_ilv_index.sv
module chan_ilv_index
    import chan_ilv_pkg::*;
#(
    parameter int W     = 46,
    parameter int IS_W  = 4,
    parameter int LG_W  = 2,
    parameter int IDX_W = 3,
    localparam int NPAIR = (HASH_HI - HASH_LO) / 2 + 1
) (
    input  logic [W-1:0]     addr_i,
    input  logic [IS_W-1:0]  ishift_i,
    input  logic [LG_W-1:0]  lg_c_i,
    input  logic             hash_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [1:0]       pair [NPAIR];
    logic [1:0]       fold;
    logic [IDX_W-1:0] raw;
    logic [IDX_W-1:0] wmask;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair[g] = addr_i[HASH_LO + 2*g +: 2];
    end

    always_comb begin
        fold = 2'b00;
        for (int k = 0; k < NPAIR; k++) begin
            fold = fold ^ pair[k];
        end
        raw = IDX_W'(addr_i >> ishift_i);
        if (hash_i) begin
            raw[1:0] = raw[1:0] ^ fold;
        end
        wmask = (IDX_W'(1) << lg_c_i) - IDX_W'(1);
        idx_o = raw & wmask;
    end
endmodule

// File: rtl/chan_ilv_step.sv
module chan_ilv_step #(
    parameter int W    = 46,
    parameter int SH_W = 5,
    parameter int LG_W = 2
) (
    input  logic [W-1:0]    val_i,
    input  logic [W-1:0]    low_i,
    input  logic [SH_W-1:0] sh_i,
    input  logic [LG_W-1:0] lg_i,
    output logic [W-1:0]    res_o
);
    logic [W-1:0] keep;
    logic [W-1:0] upper;

    always_comb begin
        keep  = (W'(1) << sh_i) - W'(1);
        upper = (val_i >> sh_i) >> lg_i;
        res_o = (upper << sh_i) | (low_i & keep);
    end
endmodule

// File: rtl/chan_ilv_xlat.sv
module chan_ilv_xlat
    import chan_ilv_pkg::*;
#(
    parameter int ADDR_W = 46,
    parameter int WAYS_W = 4,
    parameter int TGT_N  = 8,
    parameter int CH_W   = 3,
    localparam int LIST_W = TGT_N * CH_W,
    localparam int CNT_W  = $clog2(TGT_N + 1),
    localparam int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0] in_offset,
    input  logic [WAYS_W-1:0] in_sock_ways,
    input  logic [WAYS_W-1:0] in_chan_ways,
    input  logic [1:0]        in_sock_gran,
    input  logic [1:0]        in_chan_gran,
    input  logic              in_chan_shift,
    input  logic              in_chan_hash,
    input  logic [CNT_W-1:0]  in_tgt_count,
    input  logic [LIST_W-1:0] in_tgt_list,
    output logic              out_valid,
    output logic [2:0]        out_fail,
    output logic [CH_W-1:0]   out_chan_id,
    output logic [ADDR_W-1:0] out_chan_addr
);
    // ---------------- stage 1: decode and subtract ----------------
    cfg_t              cfg_d;
    logic              s1_vld;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s1_diff;
    logic              s1_under;
    cfg_t              s1_cfg;
    logic              s1_hash;
    logic [LIST_W-1:0] s1_list;
    logic [CNT_W-1:0]  s1_cnt;

    chan_ilv_cfg #(.WAYS_W(WAYS_W)) cfg_i (
        .sock_ways_i (in_sock_ways),
        .chan_ways_i (in_chan_ways),
        .sock_gran_i (in_sock_gran),
        .chan_gran_i (in_chan_gran),
        .chan_shift_i(in_chan_shift),
        .cfg_o       (cfg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= in_valid;
        end
        s1_addr  <= in_addr;
        s1_diff  <= in_addr - in_offset;
        s1_under <= (in_offset > in_addr);
        s1_cfg   <= cfg_d;
        s1_hash  <= in_chan_hash;
        s1_list  <= in_tgt_list;
        s1_cnt   <= in_tgt_count;
    end

    // ---------------- stage 2: index and socket step ----------------
    logic [IDX_W-1:0]  idx_d;
    logic [ADDR_W-1:0] t_d;
    logic              tgt_ok;
    fail_e             fail_d;

    chan_ilv_index #(.W(ADDR_W), .IS_W(4), .LG_W(2), .IDX_W(IDX_W)) index_i (
        .addr_i  (s1_addr),
        .ishift_i(s1_cfg.ishift),
        .lg_c_i  (s1_cfg.lg_c),
        .hash_i  (s1_hash),
        .idx_o   (idx_d)
    );

    chan_ilv_step #(.W(ADDR_W), .SH_W(5), .LG_W(2)) sock_step_i (
        .val_i(s1_diff),
        .low_i(s1_addr),
        .sh_i (s1_cfg.sshift),
        .lg_i (s1_cfg.lg_s),
        .res_o(t_d)
    );

    always_comb begin
        tgt_ok = (CNT_W'(idx_d) < s1_cnt) && (32'(idx_d) < TGT_N);
        if (s1_cfg.three) begin
            fail_d = FAIL_THREE;
        end else if (!s1_cfg.ways_ok) begin
            fail_d = FAIL_WAYS;
        end else if (!tgt_ok) begin
            fail_d = FAIL_TGT;
        end else if (s1_under) begin
            fail_d = FAIL_UNDER;
        end else begin
            fail_d = FAIL_NONE;
        end
    end

    logic              s2_vld;
    logic [ADDR_W-1:0] s2_addr;
    logic [ADDR_W-1:0] s2_t;
    logic [IDX_W-1:0]  s2_idx;
    logic [CNT_W-1:0]  s2_cnt;
    logic [4:0]        s2_cshift;
    logic [1:0]        s2_lgc;
    fail_e             s2_fail;
    logic [LIST_W-1:0] s2_list;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
        end
        s2_addr   <= s1_addr;
        s2_t      <= t_d;
        s2_idx    <= idx_d;
        s2_cnt    <= s1_cnt;
        s2_cshift <= s1_cfg.cshift;
        s2_lgc    <= s1_cfg.lg_c;
        s2_fail   <= fail_d;
        s2_list   <= s1_list;
    end

    // ---------------- stage 3: channel step and select ----------------
    logic [ADDR_W-1:0] c_d;
    logic [CH_W-1:0]   id_d;

    chan_ilv_step #(.W(ADDR_W), .SH_W(5), .LG_W(2)) chan_step_i (
        .val_i(s2_t),
        .low_i(s2_addr),
        .sh_i (s2_cshift),
        .lg_i (s2_lgc),
        .res_o(c_d)
    );

    always_comb begin
        id_d = '0;
        for (int k = 0; k < TGT_N; k++) begin
            if (32'(s2_idx) == k) begin
                id_d = s2_list[k*CH_W +: CH_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_fail      <= FAIL_NONE;
            out_chan_id   <= '0;
            out_chan_addr <= '0;
        end else begin
            out_valid <= s2_vld;
            out_fail  <= s2_fail;
            if (s2_fail == FAIL_NONE) begin
                out_chan_id   <= id_d;
                out_chan_addr <= c_d;
            end else begin
                out_chan_id   <= '0;
                out_chan_addr <= '0;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid); // R1

    AST_PIPE_STEP: assert property (@(posedge clk) disable iff (rst)
        s2_vld |=> out_valid); // R2

    AST_THREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_cfg.three) |=> (s2_fail == FAIL_THREE)); // R7

    AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && s2_fail == FAIL_NONE) |-> (CNT_W'(s2_idx) < s2_cnt)); // R9

    AST_FAIL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fail != 3'd0) |-> (out_chan_addr == '0 && out_chan_id == '0)); // R11

endmodule

// File: tb/chan_ilv_xlat_tb_top.sv
`timescale 1ns/1ps
module chan_ilv_xlat_tb_top;
    localparam int AW = 46;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [AW-1:0] in_offset = '0;
    logic [3:0]    in_sock_ways = 4'd1;
    logic [3:0]    in_chan_ways = 4'd1;
    logic [1:0]    in_sock_gran = 2'd0;
    logic [1:0]    in_chan_gran = 2'd0;
    logic          in_chan_shift = 1'b0;
    logic          in_chan_hash = 1'b0;
    logic [3:0]    in_tgt_count = 4'd8;
    logic [23:0]   in_tgt_list = '0;
    logic          out_valid;
    logic [2:0]    out_fail;
    logic [2:0]    out_chan_id;
    logic [AW-1:0] out_chan_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [2:0]    q_fail[$];
    logic [2:0]    q_id[$];
    logic [AW-1:0] q_addr[$];
    int            q_stamp[$];
    string         q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chan_ilv_xlat dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_offset(in_offset), .in_sock_ways(in_sock_ways),
        .in_chan_ways(in_chan_ways), .in_sock_gran(in_sock_gran),
        .in_chan_gran(in_chan_gran), .in_chan_shift(in_chan_shift),
        .in_chan_hash(in_chan_hash), .in_tgt_count(in_tgt_count),
        .in_tgt_list(in_tgt_list), .out_valid(out_valid),
        .out_fail(out_fail), .out_chan_id(out_chan_id),
        .out_chan_addr(out_chan_addr)
    );

    function automatic int gshift(input int g, input bit sh);
        case (g)
            0: return sh ? 7 : 6;
            1: return 8;
            2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic bit pow2w(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8);
    endfunction

    task automatic model(input longint unsigned a, input longint unsigned o,
                         input int sw, input int cw, input int sg, input int cg,
                         input bit sh, input bit hh, input int cnt,
                         input logic [23:0] lst,
                         output logic [2:0] f, output logic [2:0] id,
                         output logic [AW-1:0] ca);
        longint unsigned idx, t, c, sm, cm;
        int ss, cs;
        f = 3'd0; id = 3'd0; ca = '0;
        if (cw == 3) begin
            f = 3'd2;
        end else if (!pow2w(sw) || !pow2w(cw)) begin
            f = 3'd1;
        end else begin
            idx = a >> 6;
            if (sh) idx = idx >> 1;
            idx = idx / longint'(sw);
            if (hh) begin
                for (int i = 12; i <= 26; i += 2) idx = idx ^ ((a >> i) & 64'd3);
            end
            idx = idx % longint'(cw);
            if (idx >= longint'(cnt)) begin
                f = 3'd3;
            end else if (o > a) begin
                f = 3'd4;
            end else begin
                ss = gshift(sg, sh);
                cs = gshift(cg, sh);
                sm = (64'd1 << ss) - 1;
                cm = (64'd1 << cs) - 1;
                t = (((a - o) >> ss) / longint'(sw)) << ss;
                t = t | (a & sm);
                c = ((t >> cs) / longint'(cw)) << cs;
                c = c | (a & cm);
                id = lst[idx*3 +: 3];
                ca = c[AW-1:0];
            end
        end
    endtask

    task automatic send(input longint unsigned a, input longint unsigned o,
                        input int sw, input int cw, input int sg, input int cg,
                        input bit sh, input bit hh, input int cnt,
                        input logic [23:0] lst, input string tag);
        logic [2:0] f, id;
        logic [AW-1:0] ca;
        @(negedge clk);
        in_valid      = 1'b1;
        in_addr       = a[AW-1:0];
        in_offset     = o[AW-1:0];
        in_sock_ways  = 4'(sw);
        in_chan_ways  = 4'(cw);
        in_sock_gran  = 2'(sg);
        in_chan_gran  = 2'(cg);
        in_chan_shift = sh;
        in_chan_hash  = hh;
        in_tgt_count  = 4'(cnt);
        in_tgt_list   = lst;
        model(a & ((64'd1 << AW) - 1), o & ((64'd1 << AW) - 1),
              sw, cw, sg, cg, sh, hh, cnt, lst, f, id, ca);
        q_fail.push_back(f);
        q_id.push_back(id);
        q_addr.push_back(ca);
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_fail.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: result with no pending request (act out_valid=1, exp 0)");
            end else begin
                automatic logic [2:0]    ef = q_fail.pop_front();
                automatic logic [2:0]    ei = q_id.pop_front();
                automatic logic [AW-1:0] ea = q_addr.pop_front();
                automatic int            es = q_stamp.pop_front();
                automatic string         et = q_tag.pop_front();
                checks++;
                if (out_fail !== ef || out_chan_id !== ei || out_chan_addr !== ea) begin
                    errors++;
                    $display("FAIL %s: act fail=%0d id=%0d addr=%h exp fail=%0d id=%0d addr=%h",
                             et, out_fail, out_chan_id, out_chan_addr, ef, ei, ea);
                end
                checks++;
                if (cyc - es != 3) begin
                    errors++;
                    $display("FAIL R2: latency act=%0d exp=3", cyc - es);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [23:0] lst;
        lst = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0} ^ 24'h924924;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid in reset act=%b exp=0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid after reset act=%b exp=0", out_valid);
        end

        // R3 basic index
        send(64'h40, 0, 1, 2, 0, 0, 0, 0, 8, lst, "R3");
        send(64'h40, 0, 1, 2, 0, 0, 1, 0, 8, lst, "R3");
        send(64'h80, 0, 1, 2, 0, 0, 1, 0, 8, lst, "R3");
        send(64'h1C0, 0, 2, 4, 0, 0, 0, 0, 8, lst, "R3");
        send(64'h3C0, 0, 1, 8, 1, 1, 0, 0, 8, lst, "R3");
        idle(5);
        // R4 hash
        send(64'h1000, 0, 1, 4, 0, 0, 0, 1, 8, lst, "R4");
        send(64'h8002040, 0, 1, 4, 0, 0, 0, 1, 8, lst, "R4");
        send(64'h0C000000, 0, 2, 8, 2, 0, 1, 1, 8, lst, "R4");
        // R5 granularity codes
        for (int g = 0; g < 4; g++) begin
            send(64'h2345_6789_ABCD, 64'h1000, 2, 2, g, g, 0, 0, 8, lst, "R5");
            send(64'h2345_6789_ABCD, 64'h1000, 2, 2, g, 0, 1, 0, 8, lst, "R5");
        end
        // R6 offsets and mixed ways
        send(64'h3FFF_FFFF_FFFF, 64'h10_0000, 8, 8, 1, 2, 0, 0, 8, lst, "R6");
        send(64'h1234_5678, 64'h1234_5678, 4, 2, 2, 2, 0, 0, 8, lst, "R10");
        // R7 three-way priority
        send(64'h40, 64'h80, 3, 3, 0, 0, 0, 0, 0, lst, "R7");
        send(64'h1000, 0, 1, 3, 0, 0, 0, 0, 8, lst, "R7");
        // R8 bad ways
        send(64'h1000, 0, 3, 2, 0, 0, 0, 0, 8, lst, "R8");
        send(64'h1000, 0, 0, 2, 0, 0, 0, 0, 8, lst, "R8");
        send(64'h1000, 64'h2000, 2, 5, 0, 0, 0, 0, 0, lst, "R8");
        // R9 index beyond list, beats underflow
        send(64'h1C0, 64'h400, 1, 8, 0, 0, 0, 0, 7, lst, "R9");
        send(64'h000, 0, 1, 8, 0, 0, 0, 0, 0, lst, "R9");
        // R10 underflow, R11 zeroed outputs
        send(64'h1C0, 64'h1C1, 1, 8, 0, 0, 0, 0, 8, lst, "R10");
        send(64'h3_0000_0040, 64'h3_0000_0041, 2, 2, 3, 3, 0, 0, 8, lst, "R11");
        idle(6);

        // random back-to-back traffic
        for (int n = 0; n < 400; n++) begin
            automatic longint unsigned a = {$urandom, $urandom} & ((64'd1 << AW) - 1);
            automatic longint unsigned o = ($urandom % 4 == 0) ? (a + 1) : (a >> ($urandom % 20 + 1));
            automatic int wsel[4] = '{1, 2, 4, 8};
            automatic int sw = ($urandom % 16 == 0) ? int'($urandom % 16) : wsel[$urandom % 4];
            automatic int cw = ($urandom % 16 == 0) ? int'($urandom % 16) : wsel[$urandom % 4];
            automatic int cnt = ($urandom % 3 == 0) ? int'($urandom % 9) : 8;
            automatic logic [23:0] rl = 24'($urandom);
            send(a, o, sw, cw, int'($urandom % 4), int'($urandom % 4),
                 1'($urandom), 1'($urandom), cnt, rl, "R6");
            if ($urandom % 5 == 0) idle(1);
        end
        idle(8);

        checks++;
        if (q_fail.size() != 0) begin
            errors++;
            $display("FAIL R2: pending results act=%0d exp=0", q_fail.size());
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule